// File: doc/BRIEF.md
# Test Data Register Selector

This block sits behind an existing test access port state machine. It decodes the 4-bit instruction held by that controller and routes the serial test data path through one of four data registers. The four registers are a single bypass cell, a one-bit system reset cell, a parameterized identification register, and an external boundary-scan chain reached through a serial port. The controller supplies the test clock, the data-register capture, shift and update strobes, the test-logic reset, and the current instruction. The block returns the serial test output, a system reset request, and two mode flags that tell the boundary cells which instruction is in force.

The reset cell is a test-specific instruction. While it is selected, shifting a one into its single cell asserts the system reset request at once, because no update latch stands in between. The request stays asserted for as long as the cell holds a one, including after another instruction is loaded. Only shifting a zero in under the same instruction, or a test-logic reset, clears it. This instruction has no effect on the state machine or the instruction register outside.

All data registers shift on the rising test clock edge. The serial output is retimed on the falling edge.

Top module: `jtag_dr_select`

## Requirements
- R1: Instruction decoding works as follows:
  - Code 0x0 selects the boundary chain and raises `mode_extest`.
  - Code 0x2 selects the boundary chain and raises `mode_sample`.
  - Code 0x1 selects the identification register.
  - Code 0xC selects the reset cell.
  - Every other code, 0xF included, selects the bypass cell with both mode flags low.
- R2: With bypass selected, a capture strobe loads 0 into the bypass cell. Each shift cycle then delays `tdi` by exactly one cycle on its way to `tdo`.
- R3: With the identification register selected, a capture strobe loads `ID_VALUE`. Shift cycles then present its bits least significant first on `tdo` while `tdi` enters at the most significant end.
- R4: With code 0xC selected, each shift cycle loads `tdi` into the reset cell on the rising edge. `sys_reset_req` equals that cell from the same edge, with no update stage, and capture or update strobes leave the cell unchanged.
- R5: The reset cell keeps its value while any other instruction is selected, whatever the strobes do.
- R6: While `tlr` is high, the block behaves as follows:
  - The reset cell clears asynchronously.
  - `tdo` is 0.
  - The identification register is forced as the selection, so both mode flags are low and no boundary strobe is passed on.
- R7: `tdo` changes only on a falling test clock edge during which `shift_dr` is high, and then takes the output bit of the selected register. At all other times it holds.
- R8: `bsc_si` always equals `tdi`. `bsc_capture`, `bsc_shift` and `bsc_update` follow the matching controller strobes only while code 0x0 or 0x2 is selected, and are 0 otherwise.
- R9: With the boundary chain selected and `shift_dr` high, the falling edge copies `bsc_so` to `tdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tlr | input | 1 | Test-logic reset, active high, asynchronous |
| capture_dr | input | 1 | Capture-DR strobe from the controller |
| shift_dr | input | 1 | Shift-DR strobe from the controller |
| update_dr | input | 1 | Update-DR strobe from the controller |
| ir_code | input | 4 | Current instruction |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| sys_reset_req | output | 1 | System reset request from the reset cell |
| mode_sample | output | 1 | Sample/preload instruction active |
| mode_extest | output | 1 | External test instruction active |
| bsc_si | output | 1 | Serial data to the boundary chain |
| bsc_so | input | 1 | Serial data back from the boundary chain |
| bsc_capture | output | 1 | Capture strobe to the boundary chain |
| bsc_shift | output | 1 | Shift strobe to the boundary chain |
| bsc_update | output | 1 | Update strobe to the boundary chain |

## Verification
The assertions assume the following about the inputs:
- The controller changes `ir_code` and the three strobes only away from both clock edges.
- `bsc_so` is a known value whenever the chain is being shifted.
- `tlr` starts high, so every register begins from a defined value.

The stimulus meets these assumptions in three ways. It drives every input one nanosecond after a rising edge. It holds `bsc_so` at a defined level from time zero. It opens each run with several cycles of `tlr` before any strobe is raised.

// File: rtl/jtag_dr_pkg.sv
package jtag_dr_pkg;

  localparam int IR_W = 4;

  localparam logic [IR_W-1:0] OP_EXTEST = 4'h0;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'h1;
  localparam logic [IR_W-1:0] OP_SAMPLE = 4'h2;
  localparam logic [IR_W-1:0] OP_RSTREG = 4'hC;

  typedef enum logic [1:0] {
    DR_BYPASS = 2'd0,
    DR_IDENT  = 2'd1,
    DR_RESET  = 2'd2,
    DR_BSCAN  = 2'd3
  } dr_sel_e;

  typedef struct packed {
    dr_sel_e sel;
    logic    sample;
    logic    extest;
  } dr_mode_t;

  // Map an instruction to its data register and boundary mode flags.
  function automatic dr_mode_t decode_ir(input logic [IR_W-1:0] code);
    dr_mode_t m;
    m.sel    = DR_BYPASS;
    m.sample = 1'b0;
    m.extest = 1'b0;
    case (code)
      OP_EXTEST: begin m.sel = DR_BSCAN; m.extest = 1'b1; end
      OP_SAMPLE: begin m.sel = DR_BSCAN; m.sample = 1'b1; end
      OP_IDCODE: m.sel = DR_IDENT;
      OP_RSTREG: m.sel = DR_RESET;
      default:   m.sel = DR_BYPASS;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/jtag_dr_decode.sv
module jtag_dr_decode
  import jtag_dr_pkg::*;
(
  input  logic            tlr,
  input  logic [IR_W-1:0] ir_code,
  output dr_mode_t        mode_o
);

  localparam dr_mode_t RESET_MODE = '{sel: DR_IDENT, sample: 1'b0, extest: 1'b0};

  always_comb begin
    if (tlr) mode_o = RESET_MODE;   // R6: reset forces the identification path
    else     mode_o = decode_ir(ir_code);
  end

endmodule

// File: rtl/jtag_dr_bypass.sv
module jtag_dr_bypass (
  input  logic tck,
  input  logic tlr,
  input  logic sel,
  input  logic capture,
  input  logic shift,
  input  logic tdi,
  output logic so
);

  logic byp_q;
  logic cap_ev;
  logic sh_ev;

  assign cap_ev = sel && capture;
  assign sh_ev  = sel && shift && !capture;

  always_ff @(posedge tck or posedge tlr) begin
    if (tlr)         byp_q <= 1'b0;
    else if (cap_ev) byp_q <= 1'b0;
    else if (sh_ev)  byp_q <= tdi;
  end

  assign so = byp_q;

  a_r2_capture_zero: assert property (@(posedge tck) disable iff (tlr)
    cap_ev |=> !so);
  a_r2_shift_delay: assert property (@(posedge tck) disable iff (tlr)
    sh_ev |=> so == $past(tdi));

endmodule

// File: rtl/jtag_dr_reset_bit.sv
module jtag_dr_reset_bit (
  input  logic tck,
  input  logic tlr,
  input  logic sel,
  input  logic shift,
  input  logic tdi,
  output logic bit_o
);

  logic rst_q;
  logic load_ev;

  assign load_ev = sel && shift;

  // No update stage: the cell itself drives the request.
  always_ff @(posedge tck or posedge tlr) begin
    if (tlr)          rst_q <= 1'b0;
    else if (load_ev) rst_q <= tdi;
  end

  assign bit_o = rst_q;

  a_r4_shift_loads: assert property (@(posedge tck) disable iff (tlr)
    load_ev |=> bit_o == $past(tdi));
  a_r5_holds_otherwise: assert property (@(posedge tck) disable iff (tlr)
    !load_ev |=> $stable(bit_o));

endmodule

// File: rtl/jtag_dr_idreg.sv
module jtag_dr_idreg #(
  parameter int            ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1A7C_503F
) (
  input  logic tck,
  input  logic tlr,
  input  logic sel,
  input  logic capture,
  input  logic shift,
  input  logic tdi,
  output logic so
);

  logic [ID_W-1:0] sh_q;
  logic            cap_ev;
  logic            sh_ev;

  assign cap_ev = sel && capture;
  assign sh_ev  = sel && shift && !capture;

  always_ff @(posedge tck or posedge tlr) begin
    if (tlr)         sh_q <= ID_VALUE;
    else if (cap_ev) sh_q <= ID_VALUE;
    else if (sh_ev)  sh_q <= {tdi, sh_q[ID_W-1:1]};
  end

  assign so = sh_q[0];

  a_r3_capture_value: assert property (@(posedge tck) disable iff (tlr)
    cap_ev |=> sh_q == ID_VALUE);
  a_r3_msb_entry: assert property (@(posedge tck) disable iff (tlr)
    sh_ev |=> sh_q[ID_W-1] == $past(tdi));

endmodule

// File: rtl/jtag_dr_select.sv
module jtag_dr_select
  import jtag_dr_pkg::*;
#(
  parameter int            ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1A7C_503F
) (
  input  logic            tck,
  input  logic            tlr,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic [IR_W-1:0] ir_code,
  input  logic            tdi,
  output logic            tdo,
  output logic            sys_reset_req,
  output logic            mode_sample,
  output logic            mode_extest,
  output logic            bsc_si,
  input  logic            bsc_so,
  output logic            bsc_capture,
  output logic            bsc_shift,
  output logic            bsc_update
);

  dr_mode_t mode;
  logic     sel_byp, sel_id, sel_rst, sel_bs;
  logic     byp_so, id_so, rst_bit;
  logic     dr_so;
  logic     tdo_q;

  jtag_dr_decode u_decode (
    .tlr     (tlr),
    .ir_code (ir_code),
    .mode_o  (mode)
  );

  assign sel_byp = (mode.sel == DR_BYPASS);
  assign sel_id  = (mode.sel == DR_IDENT);
  assign sel_rst = (mode.sel == DR_RESET);
  assign sel_bs  = (mode.sel == DR_BSCAN);

  jtag_dr_bypass u_bypass (
    .tck     (tck),
    .tlr     (tlr),
    .sel     (sel_byp),
    .capture (capture_dr),
    .shift   (shift_dr),
    .tdi     (tdi),
    .so      (byp_so)
  );

  jtag_dr_reset_bit u_rstbit (
    .tck   (tck),
    .tlr   (tlr),
    .sel   (sel_rst),
    .shift (shift_dr),
    .tdi   (tdi),
    .bit_o (rst_bit)
  );

  jtag_dr_idreg #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_idreg (
    .tck     (tck),
    .tlr     (tlr),
    .sel     (sel_id),
    .capture (capture_dr),
    .shift   (shift_dr),
    .tdi     (tdi),
    .so      (id_so)
  );

  always_comb begin
    unique case (mode.sel)
      DR_BYPASS: dr_so = byp_so;
      DR_IDENT:  dr_so = id_so;
      DR_RESET:  dr_so = rst_bit;
      DR_BSCAN:  dr_so = bsc_so;
      default:   dr_so = byp_so;
    endcase
  end

  // Serial output retimed on the falling edge, held outside Shift-DR.
  always_ff @(negedge tck or posedge tlr) begin
    if (tlr)           tdo_q <= 1'b0;
    else if (shift_dr) tdo_q <= dr_so;
  end

  assign tdo           = tdo_q;
  assign sys_reset_req = rst_bit;
  assign mode_sample   = mode.sample;
  assign mode_extest   = mode.extest;
  assign bsc_si        = tdi;
  assign bsc_capture   = sel_bs && capture_dr;
  assign bsc_shift     = sel_bs && shift_dr;
  assign bsc_update    = sel_bs && update_dr;

  a_r7_tdo_hold: assert property (@(negedge tck) disable iff (tlr)
    !shift_dr |=> $stable(tdo));
  a_r9_chain_to_tdo: assert property (@(negedge tck) disable iff (tlr)
    (shift_dr && sel_bs) |=> tdo == $past(bsc_so));
  a_r6_reset_quiet: assert property (@(posedge tck)
    tlr |-> (!sys_reset_req && !mode_sample && !mode_extest && !tdo));
  a_r8_no_strobe_when_idle: assert property (@(posedge tck) disable iff (tlr)
    !(mode_sample || mode_extest) |-> !(bsc_capture || bsc_shift || bsc_update));

endmodule

// File: tb/jtag_dr_select_tb.sv
`timescale 1ns/1ps
module jtag_dr_select_tb;

  localparam logic [31:0] ID_EXP = 32'h5B3D_8A27;
  localparam logic [31:0] PAT    = 32'hC35A_9E01;

  // {ir, expect boundary path, expect sample flag, expect extest flag}
  localparam logic [6:0] VEC [16] = '{
    {4'h0, 3'b101}, {4'h1, 3'b000}, {4'h2, 3'b110}, {4'h3, 3'b000},
    {4'h4, 3'b000}, {4'h5, 3'b000}, {4'h6, 3'b000}, {4'h7, 3'b000},
    {4'h8, 3'b000}, {4'h9, 3'b000}, {4'hA, 3'b000}, {4'hB, 3'b000},
    {4'hC, 3'b000}, {4'hD, 3'b000}, {4'hE, 3'b000}, {4'hF, 3'b000}
  };

  logic       tck = 1'b0;
  logic       tlr = 1'b1;
  logic       capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic [3:0] ir_code = 4'hF;
  logic       tdi = 1'b0;
  logic       bsc_so = 1'b0;
  logic       tdo, sys_reset_req, mode_sample, mode_extest;
  logic       bsc_si, bsc_capture, bsc_shift, bsc_update;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 tck = ~tck;

  jtag_dr_select #(.ID_W(32), .ID_VALUE(ID_EXP)) u_dut (
    .tck(tck), .tlr(tlr), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .ir_code(ir_code), .tdi(tdi), .tdo(tdo),
    .sys_reset_req(sys_reset_req), .mode_sample(mode_sample),
    .mode_extest(mode_extest), .bsc_si(bsc_si), .bsc_so(bsc_so),
    .bsc_capture(bsc_capture), .bsc_shift(bsc_shift), .bsc_update(bsc_update)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One test clock: drive, sample tdo after the falling edge, return after rising edge.
  task automatic tick(input logic cap, input logic sh, input logic up,
                      input logic din, output logic seen);
    capture_dr = cap; shift_dr = sh; update_dr = up; tdi = din;
    @(negedge tck); #1; seen = tdo;
    @(posedge tck); #1;
    capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic s;
    logic [31:0] got;
    repeat (3) @(posedge tck);
    #1;
    // R6 reset state
    ir_code = 4'h2;
    #0.2;
    chk("R6 tdo in reset", {31'b0, tdo}, 0);
    chk("R6 flags in reset", {30'b0, mode_sample, mode_extest}, 0);
    chk("R6 req in reset", {31'b0, sys_reset_req}, 0);
    shift_dr = 1'b1; #0.2;
    chk("R6 no chain strobe in reset", {31'b0, bsc_shift}, 0);
    shift_dr = 1'b0;
    tlr = 1'b0;

    // R1/R8 decode table
    foreach (VEC[i]) begin
      @(posedge tck); #1;
      ir_code = VEC[i][6:3]; shift_dr = 1'b1; capture_dr = 1'b1; update_dr = 1'b1;
      tdi = VEC[i][3];
      #0.5;
      chk("R1 sample flag", {31'b0, mode_sample}, {31'b0, VEC[i][1]});
      chk("R1 extest flag", {31'b0, mode_extest}, {31'b0, VEC[i][0]});
      chk("R8 strobes", {29'b0, bsc_capture, bsc_shift, bsc_update}, {29'b0, {3{VEC[i][2]}}});
      chk("R8 si follows tdi", {31'b0, bsc_si}, {31'b0, tdi});
      shift_dr = 1'b0; capture_dr = 1'b0; update_dr = 1'b0;
    end
    @(posedge tck); #1;

    // R3 identification register
    ir_code = 4'h1;
    tick(1, 0, 0, 0, s);
    got = '0;
    for (int i = 0; i < 32; i++) begin tick(0, 1, 0, PAT[i], s); got[i] = s; end
    chk("R3 id out lsb first", got, ID_EXP);
    for (int i = 0; i < 32; i++) begin tick(0, 1, 0, 1'b0, s); got[i] = s; end
    chk("R3 tdi enters msb", got, PAT);

    // R2 bypass (undefined and 0xF)
    ir_code = 4'hF;
    tick(1, 0, 0, 1, s);
    got = '0;
    tick(0, 1, 0, 1, s); got[0] = s;
    tick(0, 1, 0, 1, s); got[1] = s;
    tick(0, 1, 0, 0, s); got[2] = s;
    tick(0, 1, 0, 1, s); got[3] = s;
    chk("R2 bypass 0xF", got, 32'b0110);
    ir_code = 4'h7;
    tick(1, 0, 0, 0, s);
    tick(0, 1, 0, 1, s); got[0] = s;
    tick(0, 1, 0, 0, s); got[1] = s;
    chk("R2 bypass undefined", {30'b0, got[1:0]}, 32'b10);

    // R4 reset cell
    ir_code = 4'hC;
    tick(0, 1, 0, 1, s);
    chk("R4 req after shift-in 1", {31'b0, sys_reset_req}, 1);
    chk("R4 tdo shows old cell", {31'b0, s}, 0);
    tick(1, 0, 1, 0, s);
    chk("R4 capture/update keep cell", {31'b0, sys_reset_req}, 1);
    // R5 held under another instruction
    ir_code = 4'hF;
    tick(0, 1, 0, 0, s);
    tick(1, 0, 1, 0, s);
    chk("R5 cell held in bypass", {31'b0, sys_reset_req}, 1);
    ir_code = 4'hC;
    tick(0, 1, 0, 0, s);
    chk("R4 tdo shows cell 1", {31'b0, s}, 1);
    chk("R4 req cleared by shift 0", {31'b0, sys_reset_req}, 0);
    tick(0, 1, 0, 1, s);
    chk("R4 req set again", {31'b0, sys_reset_req}, 1);

    // R6 asynchronous clear
    ir_code = 4'h2;
    tlr = 1'b1; #0.3;
    chk("R6 async clear req", {31'b0, sys_reset_req}, 0);
    chk("R6 flags forced low", {30'b0, mode_sample, mode_extest}, 0);
    @(posedge tck); #1;
    tlr = 1'b0;

    // R9 boundary chain through tdo, R7 hold
    ir_code = 4'h2;
    bsc_so = 1'b1;
    tick(0, 1, 0, 0, s);
    chk("R9 chain bit 1 to tdo", {31'b0, s}, 1);
    bsc_so = 1'b0;
    tick(0, 1, 0, 0, s);
    chk("R9 chain bit 0 to tdo", {31'b0, s}, 0);
    bsc_so = 1'b1;
    tick(1, 0, 0, 0, s);
    chk("R7 tdo held outside shift", {31'b0, s}, 0);
    tick(0, 0, 1, 0, s);
    chk("R7 tdo held on update", {31'b0, s}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule